// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the beats of a single DMA channel. A one-cycle start pulse, taken only while the sequencer is idle, captures a configuration. The configuration holds a source and a destination address, a transfer count in source-width units, an encoded width for each side, an address mode for each side and an encoded burst length. The sequencer then spends one cycle checking that configuration. An illegal setting ends the run with an error pulse. A legal setting starts a run of read and write beats. Each beat presents one byte address on its own valid/ready pair.

The two widths may differ. The sequencer tracks how many source bytes it has read but not yet written. It issues read beats until at least one destination word is held. It issues write beats while a full destination word is held. When the last byte is written, it raises a done pulse. The address registers are left holding the ending addresses and the count reads zero. An abort input sends the sequencer back to idle on the next edge. Bus protocol, data storage and descriptor chaining are handled by neighbouring logic.

Top module: `dma_chan_seq`

## Requirements
- R1: Width codes 0..5 select 1, 2, 4, 8, 16 and 32 bytes. A source or destination width code of 6 or 7 ends the run with an error.
- R2: Address mode 0 adds the side's own width in bytes after each of its beats, mode 1 subtracts it and mode 2 keeps the address. Mode 3 on either side ends the run with an error.
- R3: Burst code n in 0..10 means 2^n transfers, and codes 11..15 end the run with an error. The burst byte count, 2^n times the source width, must be a multiple of the destination width, or the run ends with an error.
- R4: A transfer count of zero ends the run with an error.
- R5: A source address not aligned to the source width, or a destination address not aligned to the destination width, ends the run with an error.
- R6: The total byte count, count times the source width, must be a multiple of the destination width, or the run ends with an error.
- R7: In the cycle after a start is taken, `busy` is high and neither valid is high. For an illegal configuration, `error` is high for exactly one cycle in the following cycle, with no read or write valid. The sequencer is idle one cycle later.
- R8: Read beats present `rd_valid` with the current source address. Write beats present `wr_valid` with the current destination address. Each valid and its address stay unchanged until ready. The two valids are never high together. A read is issued while fewer than one destination width of bytes is held. Writes are issued while at least one destination width is held.
- R9: One cycle after the final write handshake, `done` is high for one cycle. At that point `cur_count` is zero and `rd_addr`/`wr_addr` hold the ending addresses.
- R10: An abort while the sequencer is busy returns it to idle on the next edge. Both valids are low in the abort cycle and afterwards.
- R11: A start while busy is ignored. The running transfer continues with its own configuration. A start given together with abort is not taken.
- R12: After reset the sequencer is idle, with all valids, `done` and `error` low, and the count and addresses at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and begin (idle only) |
| abort | input | 1 | Return to idle |
| cfg_src_addr | input | AW | Source start byte address |
| cfg_dst_addr | input | AW | Destination start byte address |
| cfg_count | input | CW | Transfer count in source-width units |
| cfg_src_width | input | 3 | Source width code |
| cfg_dst_width | input | 3 | Destination width code |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_burst | input | 4 | Burst length code |
| rd_valid | output | 1 | Read beat request |
| rd_ready | input | 1 | Read beat accepted |
| rd_addr | output | AW | Current source address |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Current destination address |
| cur_count | output | CW | Remaining transfer count |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle configuration error pulse |

## Verification
The hardest conditions to reach are the individual error causes, because any one illegal field hides whether the others are checked. Each error run therefore keeps every field legal except one. The total-size and burst-size divisibility cases use a byte-wide source with a word-wide destination, so those two checks are reached alone. Unequal widths in both directions drive the held-byte accounting through runs of several reads per write and several writes per read. Ready patterns that stall drive the hold requirement. A start and a changed configuration are injected mid-run, and an abort is given after a chosen number of handshakes.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [2:0]    cfg_src_width,
  input  logic [2:0]    cfg_dst_width,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic [3:0]    cfg_burst,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] cur_count,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int TW = CW + 8;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ, S_WRITE, S_DONE, S_ERR} st_t;

  st_t           st, nxt;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    sw_q, dw_q;
  logic [1:0]    sm_q, dm_q;
  logic [3:0]    bs_q;
  logic [6:0]    held_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic [2:0] w);
    case (m)
      2'd0:    step = a + (AW'(1) << w);
      2'd1:    step = a - (AW'(1) << w);
      default: step = a;
    endcase
  endfunction

  wire [6:0] sbytes  = 7'd1 << sw_q;
  wire [6:0] dbytes  = 7'd1 << dw_q;
  wire [6:0] held_rd = held_q + sbytes;
  wire [6:0] held_wr = held_q - dbytes;

  wire bad_enc   = (sw_q > 3'd5) | (dw_q > 3'd5) | (sm_q == 2'd3) | (dm_q == 2'd3) | (bs_q > 4'd10);
  wire zero_cnt  = (cnt_q == '0);
  wire src_mis   = |(src_q & ((AW'(1) << sw_q) - AW'(1)));
  wire dst_mis   = |(dst_q & ((AW'(1) << dw_q) - AW'(1)));
  wire tot_mis   = |((TW'(cnt_q) << sw_q) & ((TW'(1) << dw_q) - TW'(1)));
  wire burst_mis = ({1'b0, bs_q} + {2'b0, sw_q}) < {2'b0, dw_q};
  wire cfg_bad   = bad_enc | zero_cnt | src_mis | dst_mis | tot_mis | burst_mis;

  wire rd_fire = (st == S_READ)  && rd_ready && !abort;
  wire wr_fire = (st == S_WRITE) && wr_ready && !abort;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (start) nxt = S_CHECK;
      S_CHECK: nxt = cfg_bad ? S_ERR : S_READ;
      S_READ:  if (rd_ready) nxt = (held_rd >= dbytes) ? S_WRITE : S_READ;
      S_WRITE: if (wr_ready) nxt = (held_wr >= dbytes) ? S_WRITE :
                                   (cnt_q == '0) ? S_DONE : S_READ;
      default: nxt = S_IDLE;
    endcase
    if (abort) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      sw_q   <= '0;
      dw_q   <= '0;
      sm_q   <= '0;
      dm_q   <= '0;
      bs_q   <= '0;
      held_q <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start && !abort) begin
        src_q  <= cfg_src_addr;
        dst_q  <= cfg_dst_addr;
        cnt_q  <= cfg_count;
        sw_q   <= cfg_src_width;
        dw_q   <= cfg_dst_width;
        sm_q   <= cfg_src_mode;
        dm_q   <= cfg_dst_mode;
        bs_q   <= cfg_burst;
        held_q <= '0;
      end
      if (rd_fire) begin
        src_q  <= step(src_q, sm_q, sw_q);
        cnt_q  <= cnt_q - CW'(1);
        held_q <= held_rd;
      end
      if (wr_fire) begin
        dst_q  <= step(dst_q, dm_q, dw_q);
        held_q <= held_wr;
      end
    end
  end

  assign rd_valid  = (st == S_READ)  && !abort;
  assign wr_valid  = (st == S_WRITE) && !abort;
  assign rd_addr   = src_q;
  assign wr_addr   = dst_q;
  assign cur_count = cnt_q;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign error     = (st == S_ERR);
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [CW-1:0] cur_count,
  input logic          busy,
  input logic          done,
  input logic          error
);
  AST_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_valid && wr_valid)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> abort || (rd_valid && $stable(rd_addr))); // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> abort || (wr_valid && $stable(wr_addr))); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) abort |=> !busy); // R10
  AST_START_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !abort |=> busy && !rd_valid && !wr_valid); // R7
  AST_ERR_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !rd_valid && !wr_valid && !done); // R7
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) done |-> cur_count == '0); // R9
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n) done || error |=> !busy); // R9
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .cur_count(cur_count), .busy(busy), .done(done), .error(error)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  logic        clk = 0, rst_n = 0, start = 0, abort = 0;
  logic [31:0] cfg_src_addr = 0, cfg_dst_addr = 0;
  logic [15:0] cfg_count = 0;
  logic [2:0]  cfg_src_width = 0, cfg_dst_width = 0;
  logic [1:0]  cfg_src_mode = 0, cfg_dst_mode = 0;
  logic [3:0]  cfg_burst = 0;
  logic        rd_ready = 0, wr_ready = 0;
  logic        rd_valid, wr_valid, busy, done, error;
  logic [31:0] rd_addr, wr_addr;
  logic [15:0] cur_count;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  dma_chan_seq #(.AW(32), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_count(cfg_count),
    .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width),
    .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode), .cfg_burst(cfg_burst),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .cur_count(cur_count), .busy(busy), .done(done), .error(error));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] nstep(input logic [31:0] a, input int m, input int bytes);
    if (m == 0) return a + bytes;
    if (m == 1) return a - bytes;
    return a;
  endfunction

  // exp_err: expected illegal; abort_at: handshakes before abort (-1 none); poke: start mid-run
  task automatic run(input string tag, input logic [31:0] s, input logic [31:0] d,
                     input int n, input int sw, input int dw, input int sm, input int dm,
                     input int bs, input bit exp_err, input int abort_at, input bit poke);
    logic [31:0] qa[$];
    bit          qw[$];
    logic [31:0] es, ed;
    int held, left, sb, db, hs;
    bit want_done;
    es = s; ed = d; sb = 1 << sw; db = 1 << dw; held = 0; left = n;
    if (!exp_err)
      while (left > 0 || held > 0) begin
        if (held >= db) begin qa.push_back(ed); qw.push_back(1); ed = nstep(ed, dm, db); held -= db; end
        else begin qa.push_back(es); qw.push_back(0); es = nstep(es, sm, sb); held += sb; left--; end
      end
    @(negedge clk);
    cfg_src_addr = s; cfg_dst_addr = d; cfg_count = 16'(n);
    cfg_src_width = 3'(sw); cfg_dst_width = 3'(dw);
    cfg_src_mode = 2'(sm); cfg_dst_mode = 2'(dm); cfg_burst = 4'(bs);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !rd_valid && !wr_valid, {"R7 check cycle ", tag}, {busy, rd_valid, wr_valid}, 3'b100);
    if (exp_err) begin
      @(negedge clk);
      chk(error && !rd_valid && !wr_valid && !done, {"R7 error pulse ", tag}, {error, rd_valid, wr_valid}, 3'b100);
      @(negedge clk);
      chk(!busy && !error, {"R7 back to idle ", tag}, {busy, error}, 0);
      return;
    end
    hs = 0; want_done = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      rd_ready = ((cyc * 7 + 3) % 5) != 0;
      wr_ready = ((cyc * 5 + 1) % 4) != 0;
      start = poke && (cyc == 3);
      if (poke && cyc == 3) begin cfg_count = 0; cfg_src_width = 3'd7; cfg_src_addr = 32'hDEAD0001; end
      if (abort_at >= 0 && hs == abort_at) begin
        abort = 1; rd_ready = 0; wr_ready = 0;
        #1;
        chk(!rd_valid && !wr_valid, {"R10 valids gated ", tag}, {rd_valid, wr_valid}, 0);
        @(negedge clk);
        abort = 0;
        chk(!busy && !rd_valid && !wr_valid && !done, {"R10 idle after abort ", tag}, busy, 0);
        return;
      end
      #1;
      if (want_done) begin
        chk(done == 1, {"R9 done pulse ", tag}, done, 1);
        chk(cur_count == 0, {"R9 count cleared ", tag}, cur_count, 0);
        chk(rd_addr == es, {"R9 source end ", tag}, rd_addr, es);
        chk(wr_addr == ed, {"R9 destination end ", tag}, wr_addr, ed);
        @(negedge clk);
        start = 0;
        chk(!busy && !done, {"R9 idle after done ", tag}, busy, 0);
        return;
      end
      if (done || error) chk(0, {"R9 early end ", tag}, {done, error}, 0);
      if (rd_valid && wr_valid) chk(0, {"R8 both valid ", tag}, 3, 1);
      if (rd_valid || wr_valid) begin
        if (qa.size() == 0) chk(0, {"R8 extra beat ", tag}, 1, 0);
        else begin
          chk(qw[0] == wr_valid, {"R8 beat kind ", tag}, wr_valid, qw[0]);
          chk((wr_valid ? wr_addr : rd_addr) == qa[0], {"R2 beat address ", tag},
              wr_valid ? wr_addr : rd_addr, qa[0]);
          if ((rd_valid && rd_ready) || (wr_valid && wr_ready)) begin
            void'(qa.pop_front()); void'(qw.pop_front()); hs++;
            if (qa.size() == 0) want_done = 1;
          end
        end
      end
      @(negedge clk);
    end
    chk(0, {"R9 no completion ", tag}, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid && !wr_valid && !done && !error, "R12 reset outputs", busy, 0);
    chk(cur_count == 0 && rd_addr == 0 && wr_addr == 0, "R12 reset registers", cur_count, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R12 idle after release", busy, 0);

    run("R2 inc words",        32'h1000, 32'h2000, 4, 2, 2, 0, 0, 2, 0, -1, 0);
    run("R1 byte to word",     32'h1001, 32'h3000, 8, 0, 2, 0, 1, 2, 0, -1, 0);
    run("R1 dword to halfs",   32'h4008, 32'h5002, 3, 3, 1, 1, 2, 0, 0, -1, 0);
    run("R1 widest",           32'h6000, 32'h7020, 2, 5, 5, 0, 1, 0, 0, -1, 0);
    run("R3 burst code 10",    32'h8000, 32'h9000, 2, 0, 0, 2, 0, 10, 0, -1, 0);
    run("R1 src code 6",       32'h1000, 32'h2000, 4, 6, 0, 0, 0, 0, 1, -1, 0);
    run("R1 dst code 7",       32'h1000, 32'h2000, 4, 0, 7, 0, 0, 0, 1, -1, 0);
    run("R2 src mode 3",       32'h1000, 32'h2000, 4, 2, 2, 3, 0, 2, 1, -1, 0);
    run("R2 dst mode 3",       32'h1000, 32'h2000, 4, 2, 2, 0, 3, 2, 1, -1, 0);
    run("R3 burst code 11",    32'h1000, 32'h2000, 4, 2, 2, 0, 0, 11, 1, -1, 0);
    run("R3 burst bytes",      32'h1000, 32'h2000, 8, 0, 2, 0, 0, 1, 1, -1, 0);
    run("R4 zero count",       32'h1000, 32'h2000, 0, 2, 2, 0, 0, 0, 1, -1, 0);
    run("R5 src misaligned",   32'h1002, 32'h2000, 4, 2, 1, 0, 0, 0, 1, -1, 0);
    run("R5 dst misaligned",   32'h1000, 32'h2004, 4, 2, 3, 0, 0, 1, 1, -1, 0);
    run("R6 total bytes",      32'h1000, 32'h2000, 6, 0, 2, 0, 0, 2, 1, -1, 0);
    run("R10 abort midway",    32'hA000, 32'hB000, 8, 1, 1, 0, 0, 0, 0, 5, 0);
    run("R11 start ignored",   32'hC000, 32'hD000, 6, 2, 2, 0, 1, 1, 0, -1, 1);
    run("R8 after abort",      32'h0F00, 32'h0E00, 5, 2, 2, 1, 0, 0, 0, -1, 0);

    @(negedge clk);
    abort = 1; start = 1; cfg_count = 16'd4; cfg_src_width = 0; cfg_dst_width = 0;
    @(negedge clk);
    abort = 0; start = 0;
    chk(!busy && !rd_valid && !wr_valid, "R11 start with abort not taken", busy, 0);
    @(negedge clk);
    chk(!busy, "R11 still idle", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule